// File: doc/BRIEF.md
# Comparator Event Interrupt Controller

This block is the clocked front end for a single analog comparator result. The raw comparator bit passes through a short synchronizer. A small state machine then tracks the synchronized level and reports rising and falling transitions. A programmable mode chooses which transitions set a sticky interrupt flag. The flag drives an interrupt request when both the local enable and a global enable input allow it.

Software reaches the block through one 8-bit control/status register, with a write strobe and a read-data output. The register also drives two analog-side controls: comparator power-off and internal-reference select. It also holds a routing bit that forwards the synchronized level to a timer capture unit.

The edge tracker has three states. `ST_LOW` means the last sample seen was 0, `ST_HIGH` means it was 1, and `ST_FROZEN` means the comparator is powered off. The transitions are:
- `ST_LOW`→`ST_HIGH` on a 1 sample. This is a rising event.
- `ST_HIGH`→`ST_LOW` on a 0 sample. This is a falling event.
- Either level state →`ST_FROZEN` while power-off is set.
- `ST_FROZEN`→`ST_LOW` or `ST_HIGH`, to match the held sample, once power-off clears. This transition raises no event.

Top module: `cmp_event_ctrl`

## Requirements
- R1: After reset the register reads 0x00, and `irq`, `cap_trig`, `pwr_off` and `ref_int` are all 0.
- R2: Register bits: 7 power-off, 6 internal-reference select, 5 comparator level, 4 event flag, 3 interrupt enable, 2 capture routing, 1:0 event mode. A write stores bits 7, 6, 3, 2, 1 and 0, and a read returns them.
- R3: Bit 5 is read-only. Writes to it are ignored. It shows a raw change driven between two clock edges at the second following rising edge, and not at the first.
- R4: Event mode encodings: 00 sets the flag on either edge, 01 never sets it, 10 sets it on a falling edge, 11 sets it on a rising edge. The flag is set at the third rising edge after the raw change.
- R5: Asserting `vec_ack` for one cycle clears the flag.
- R6: Writing 1 to bit 4 clears the flag. Writing 0 to bit 4 leaves the flag unchanged.
- R7: When an event and a clear (acknowledge or write-one) occur in the same cycle, the flag ends up set.
- R8: `irq` is 1 exactly when the flag, the interrupt enable bit and `gie` are all 1.
- R9: `cap_trig` follows the synchronized level while the capture routing bit is 1, and is 0 otherwise.
- R10: `pwr_off` reflects bit 7 and `ref_int` reflects bit 6.
- R11: While power-off is set, the synchronizer holds its last value and no event is detected. After power-off clears, a level that differs from the held value is reported as an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmp_raw | input | 1 | Asynchronous comparator result |
| bus_we | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data |
| vec_ack | input | 1 | Interrupt vector acknowledge; clears the flag |
| gie | input | 1 | Global interrupt enable |
| irq | output | 1 | Interrupt request |
| cap_trig | output | 1 | Synchronized level routed to the timer capture unit |
| pwr_off | output | 1 | Comparator power-off control |
| ref_int | output | 1 | Internal reference select control |

## Verification
If the edge tracker's state disagrees with the synchronized level, the flag is set at the wrong time. Bit 4 and `irq` then show the error three edges after a raw change: a spurious set in a mode that should stay quiet, or a missing set. A stuck synchronizer stage shows as bit 5 and `cap_trig` lagging or never following the raw input two edges after a change. A wrong flag priority shows up one cycle after an acknowledge that coincides with an event.

// File: rtl/cmp_evt_pkg.sv
package cmp_evt_pkg;

    typedef enum logic [1:0] {
        ST_LOW    = 2'd0,
        ST_HIGH   = 2'd1,
        ST_FROZEN = 2'd2
    } edge_st_e;

    typedef enum logic [1:0] {
        MODE_ANY  = 2'd0,
        MODE_RSVD = 2'd1,
        MODE_FALL = 2'd2,
        MODE_RISE = 2'd3
    } evt_mode_e;

    localparam int REG_W    = 8;
    localparam int BIT_DIS  = 7;
    localparam int BIT_REF  = 6;
    localparam int BIT_LVL  = 5;
    localparam int BIT_FLAG = 4;
    localparam int BIT_IE   = 3;
    localparam int BIT_CAP  = 2;
    localparam int BIT_M1   = 1;
    localparam int BIT_M0   = 0;

endpackage

// File: rtl/cmp_evt_sync.sv
module cmp_evt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic d,
    output logic q
);
    localparam int TOP = STAGES - 1;

    logic [TOP:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)     chain_q <= '0;
                else if (!hold) chain_q <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)     chain_q <= '0;
                else if (!hold) chain_q <= {chain_q[TOP-1:0], d};
            end
        end
    endgenerate

    assign q = chain_q[TOP];

    // R11: the synchronized level freezes while the comparator is powered off
    assert_hold_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(hold) |-> $stable(q));

endmodule

// File: rtl/cmp_evt_edge_fsm.sv
module cmp_evt_edge_fsm
    import cmp_evt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic lvl,
    output logic evt_rise,
    output logic evt_fall
);
    edge_st_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOW: begin
                if (hold)     state_d = ST_FROZEN;
                else if (lvl) state_d = ST_HIGH;
            end
            ST_HIGH: begin
                if (hold)      state_d = ST_FROZEN;
                else if (!lvl) state_d = ST_LOW;
            end
            ST_FROZEN: begin
                if (!hold) state_d = lvl ? ST_HIGH : ST_LOW;
            end
            default: state_d = ST_LOW;
        endcase
    end

    always_comb begin
        evt_rise = 1'b0;
        evt_fall = 1'b0;
        unique case (state_q)
            ST_LOW:    evt_rise = !hold && lvl;
            ST_HIGH:   evt_fall = !hold && !lvl;
            ST_FROZEN: ;
            default:   ;
        endcase
    end

    // R11: a powered-off cycle always leads into the frozen state
    assert_frozen_after_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(hold) |-> state_q == ST_FROZEN);

    // R4: a level state remembers the previous synchronized sample
    assert_state_tracks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(hold) && state_q != ST_FROZEN) |-> ((state_q == ST_HIGH) == $past(lvl)));

endmodule

// File: rtl/cmp_evt_regs.sv
module cmp_evt_regs
    import cmp_evt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    input  logic             ack,
    input  logic             evt_rise,
    input  logic             evt_fall,
    input  logic             lvl,
    output logic [REG_W-1:0] rdata,
    output logic             dis,
    output logic             refsel,
    output logic             ie,
    output logic             cap,
    output logic             flag
);
    evt_mode_e mode_q;
    logic      set_evt;
    logic      clr_evt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dis    <= 1'b0;
            refsel <= 1'b0;
            ie     <= 1'b0;
            cap    <= 1'b0;
            mode_q <= MODE_ANY;
        end else if (we) begin
            dis    <= wdata[BIT_DIS];
            refsel <= wdata[BIT_REF];
            ie     <= wdata[BIT_IE];
            cap    <= wdata[BIT_CAP];
            mode_q <= evt_mode_e'(wdata[BIT_M1:BIT_M0]);
        end
    end

    always_comb begin
        set_evt = 1'b0;
        unique case (mode_q)
            MODE_ANY:  set_evt = evt_rise || evt_fall;
            MODE_RSVD: set_evt = 1'b0;
            MODE_FALL: set_evt = evt_fall;
            MODE_RISE: set_evt = evt_rise;
            default:   set_evt = 1'b0;
        endcase
    end

    assign clr_evt = ack || (we && wdata[BIT_FLAG]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       flag <= 1'b0;
        else if (set_evt) flag <= 1'b1;
        else if (clr_evt) flag <= 1'b0;
    end

    assign rdata = {dis, refsel, lvl, flag, ie, cap, mode_q};

    // R7: an event in the same cycle as a clear leaves the flag set
    assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> flag);

    // R5: acknowledge without a coinciding event clears the flag
    assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !set_evt) |=> !flag);

    // R6: a write of 0 to the flag position keeps the flag
    assert_w0_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !ack && !(we && wdata[BIT_FLAG])) |=> flag);

    // R4: the reserved mode never raises a clear flag
    assert_rsvd_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_RSVD && !flag) |=> !flag);

endmodule

// File: rtl/cmp_event_ctrl.sv
module cmp_event_ctrl
    import cmp_evt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmp_raw,
    input  logic             bus_we,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    input  logic             vec_ack,
    input  logic             gie,
    output logic             irq,
    output logic             cap_trig,
    output logic             pwr_off,
    output logic             ref_int
);
    logic lvl_s;
    logic rise_s, fall_s;
    logic dis_s, ref_s, ie_s, cap_s, flag_s;

    cmp_evt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (dis_s),
        .d     (cmp_raw),
        .q     (lvl_s)
    );

    cmp_evt_edge_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (dis_s),
        .lvl      (lvl_s),
        .evt_rise (rise_s),
        .evt_fall (fall_s)
    );

    cmp_evt_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (bus_we),
        .wdata    (bus_wdata),
        .ack      (vec_ack),
        .evt_rise (rise_s),
        .evt_fall (fall_s),
        .lvl      (lvl_s),
        .rdata    (bus_rdata),
        .dis      (dis_s),
        .refsel   (ref_s),
        .ie       (ie_s),
        .cap      (cap_s),
        .flag     (flag_s)
    );

    assign irq      = flag_s && ie_s && gie;
    assign cap_trig = cap_s && lvl_s;
    assign pwr_off  = dis_s;
    assign ref_int  = ref_s;

    // R8: a request never appears while the global enable is low
    assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (gie && bus_rdata[BIT_IE] && bus_rdata[BIT_FLAG]));

    // R9: the capture trigger stays idle unless routing is enabled
    assert_cap_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rdata[BIT_CAP] |-> !cap_trig);

endmodule

// File: tb/cmp_event_ctrl_bench.sv
module cmp_event_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmp_raw = 1'b0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       vec_ack = 1'b0;
    logic       gie = 1'b0;
    logic       irq, cap_trig, pwr_off, ref_int;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    cmp_event_ctrl u_cmp_event_ctrl (
        .clk(clk), .rst_n(rst_n), .cmp_raw(cmp_raw),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .vec_ack(vec_ack), .gie(gie), .irq(irq), .cap_trig(cap_trig),
        .pwr_off(pwr_off), .ref_int(ref_int)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] v);
        @(negedge clk);
        bus_we = 1'b1;
        bus_wdata = v;
        @(negedge clk);
        bus_we = 1'b0;
        bus_wdata = 8'h00;
    endtask

    function automatic logic mode_hit(input int m, input logic rising);
        return (m == 0) || (m == 2 && !rising) || (m == 3 && rising);
    endfunction

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        check("R1 reg", bus_rdata, 8'h00);
        check("R1 outs", {4'b0, irq, cap_trig, pwr_off, ref_int}, 8'h00);

        // R4 R3 R8 R6: sweep every mode and edge direction
        for (int m = 0; m < 4; m++) begin
            for (int d = 0; d < 2; d++) begin
                logic exp;
                exp = mode_hit(m, d[0]);
                gie = 1'b1;
                cmp_raw = !d[0];
                tick(4);
                wr(8'h18 | 8'(m));
                check("R6 w1c", {7'b0, bus_rdata[4]}, 8'h00);
                cmp_raw = d[0];
                tick(1);
                check("R3 first edge", {7'b0, bus_rdata[5]}, {7'b0, !d[0]});
                tick(1);
                check("R3 second edge", {7'b0, bus_rdata[5]}, {7'b0, d[0]});
                check("R4 not yet", {7'b0, bus_rdata[4]}, 8'h00);
                tick(1);
                check("R4 flag", {7'b0, bus_rdata[4]}, {7'b0, exp});
                check("R8 irq", {7'b0, irq}, {7'b0, exp});
                if (exp) begin
                    for (int e = 0; e < 2; e++) begin
                        for (int g = 0; g < 2; g++) begin
                            gie = g[0];
                            wr({4'b0, e[0], 1'b0, 2'(m)});
                            check("R6 w0 keeps", {7'b0, bus_rdata[4]}, 8'h01);
                            check("R8 gate", {7'b0, irq}, {7'b0, e[0] & g[0]});
                        end
                    end
                end
            end
        end

        // R3: write to level bit ignored (level is 0 now)
        cmp_raw = 1'b0;
        tick(4);
        wr(8'h30);
        check("R3 ro", bus_rdata, 8'h00);

        // R2 R10 R11: full write, power-off holds level
        wr(8'hCF);
        check("R2 readback", bus_rdata, 8'hCF);
        check("R10 outs", {6'b0, pwr_off, ref_int}, 8'h03);
        cmp_raw = 1'b1;
        tick(5);
        check("R11 held level", {7'b0, bus_rdata[5]}, 8'h00);
        check("R11 no event", {7'b0, bus_rdata[4]}, 8'h00);
        check("R9 held route", {7'b0, cap_trig}, 8'h00);
        wr(8'h00);
        check("R10 cleared", {6'b0, pwr_off, ref_int}, 8'h00);
        tick(2);
        check("R11 resume level", {7'b0, bus_rdata[5]}, 8'h01);
        tick(1);
        check("R11 edge after resume", {7'b0, bus_rdata[4]}, 8'h01);

        // R5 R7: acknowledge against a coinciding event
        wr(8'h10);
        cmp_raw = 1'b0;
        tick(3);
        check("R4 any fall", {7'b0, bus_rdata[4]}, 8'h01);
        cmp_raw = 1'b1;
        tick(2);
        vec_ack = 1'b1;
        tick(1);
        vec_ack = 1'b0;
        check("R7 set wins ack", {7'b0, bus_rdata[4]}, 8'h01);
        vec_ack = 1'b1;
        tick(1);
        vec_ack = 1'b0;
        check("R5 ack clears", {7'b0, bus_rdata[4]}, 8'h00);

        // R7 with write-one coinciding
        cmp_raw = 1'b0;
        tick(1);
        @(negedge clk);
        bus_we = 1'b1;
        bus_wdata = 8'h10;
        @(negedge clk);
        bus_we = 1'b0;
        bus_wdata = 8'h00;
        check("R7 set wins w1c", {7'b0, bus_rdata[4]}, 8'h01);

        // R9: capture routing
        wr(8'h14);
        check("R9 routed low", {7'b0, cap_trig}, 8'h00);
        cmp_raw = 1'b1;
        tick(2);
        check("R9 routed high", {7'b0, cap_trig}, 8'h01);
        wr(8'h10);
        check("R9 unrouted", {7'b0, cap_trig}, 8'h00);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule